// File: doc/BRIEF.md
# Byte-Lane True Dual-Port Memory

This block is a synthesizable storage array with two fully independent access ports, A and B, that share one clock. In any cycle each port can read one word, write any subset of one word's byte lanes, or stay idle. Both ports work in the same cycle, to the same address or to different addresses. Each port has its own lane write-enable vector. A lane is written only when the port enable and that lane's bit are both high.

The read path of each port is a chain of registers whose depth is a parameter. A read started in one cycle shows up on the port's output a fixed number of cycles later. The final register holds its value until the next read reaches it, so write cycles and idle cycles leave the output alone. When the latency is zero the output follows the addressed word combinationally. Reset clears only the final output register of each port. It never touches the stored words, so data written before a reset can still be read after it.

Top module: `dpram_bytelane`

## Requirements
- R1: A port-A cycle with `a_en` high writes, at address `a_addr`, exactly those lanes whose `a_we` bit is set. Bit i of `a_we` controls data bits [LANE_W*i+LANE_W-1 : LANE_W*i]. Lanes whose bit is clear keep their stored value.
- R2: Port B writes with the same lane rule through `b_en`, `b_we`, `b_addr` and `b_wdata`. It does so in the same cycle as, and independently of, any operation on port A.
- R3: A read cycle is one with the enable high and every write-enable bit low. The addressed word appears on that port's read output LATENCY cycles after the read cycle. Back-to-back reads come out one per cycle, in order.
- R4: A write cycle (enable high with any write-enable bit set) or a disabled cycle starts no read. The read output keeps the last value delivered to it until a later read arrives.
- R5: While `rst_n` is low at a rising clock edge, both read outputs become zero. Read operations in flight are dropped. The stored words are unchanged and can be read back after reset.
- R6: When one port reads an address in the same cycle that the other port writes it, the reading port returns the data stored before that write.
- R7: When both ports write the same address in one cycle, each lane written by only one port takes that port's data. A lane written by both ports takes port B's data, and users should not depend on this.
- R8: With LATENCY set to 0, each read output equals the stored word at its port's current address within the same cycle.
- R9: With LANE_W equal to DATA_W, the write-enable vector is one bit wide. A write then replaces the whole word, and a write-enable bit with the port enable low writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low reset; clears the read output registers |
| a_en | input | 1 | Port A operation enable |
| a_we | input | DATA_W/LANE_W | Port A per-lane write enables |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| b_en | input | 1 | Port B operation enable |
| b_we | input | DATA_W/LANE_W | Port B per-lane write enables |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |

## Verification
The bench first fills every word with full-width writes. It then runs directed patterns. Single-port partial-lane writes separate lane masking from whole-word writes. Back-to-back reads show whether the delay is per read or merely a fixed shift. Reads followed by writes and idle cycles separate a held output from one that reloads on every enabled cycle. Same-address read/write pairs across ports separate old-data from new-data return, and disjoint-lane writes from both ports to one word show whether the lanes merge. After these, a long random run with addresses packed into a few words makes port interactions frequent. A second instance with zero latency and one full-word lane covers the combinational read path and the single-bit write enable.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  // A port reads only when enabled with no lane selected for writing.
  function automatic port_op_e decode_op(input logic en, input logic any_lane);
    if (!en)           return OP_IDLE;
    else if (any_lane) return OP_WRITE;
    else               return OP_READ;
  endfunction

endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 72,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_a,
  input  logic [DATA_W/LANE_W-1:0]   we_a,
  input  logic [ADDR_W-1:0]          addr_a,
  input  logic [DATA_W-1:0]          din_a,
  input  logic                       en_b,
  input  logic [DATA_W/LANE_W-1:0]   we_b,
  input  logic [ADDR_W-1:0]          addr_b,
  input  logic [DATA_W-1:0]          din_b,
  output logic [DATA_W-1:0]          rd_a,
  output logic [DATA_W-1:0]          rd_b
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  lane_wr_a;
  logic [LANES-1:0]  lane_wr_b;

  // Lane strobes: port enable gates every lane bit.
  always_comb begin
    lane_wr_a = {LANES{en_a}} & we_a;
    lane_wr_b = {LANES{en_b}} & we_b;
  end

  // Port B is applied after port A, so B owns a doubly written lane.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_wr_a[l]) mem[addr_a][l*LANE_W +: LANE_W] <= din_a[l*LANE_W +: LANE_W];
      if (lane_wr_b[l]) mem[addr_b][l*LANE_W +: LANE_W] <= din_b[l*LANE_W +: LANE_W];
    end
  end

  // Read side sees contents before this edge's writes.
  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R1: port A lane lands when B does not also hit it
    assert_a_lane_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a && we_a[i] && !(en_b && we_b[i] && addr_b == addr_a))
      |=> mem[$past(addr_a)][i*LANE_W +: LANE_W] == $past(din_a[i*LANE_W +: LANE_W]));

    // R1: unselected lane keeps its value unless B writes it
    assert_lane_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a && !we_a[i] && !(en_b && we_b[i] && addr_b == addr_a))
      |=> mem[$past(addr_a)][i*LANE_W +: LANE_W] == $past(mem[addr_a][i*LANE_W +: LANE_W]));

    // R2 and R7: a port B lane write always lands
    assert_b_lane_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_b && we_b[i])
      |=> mem[$past(addr_b)][i*LANE_W +: LANE_W] == $past(din_b[i*LANE_W +: LANE_W]));
  end

endmodule

// File: rtl/dpram_read_pipe.sv
module dpram_read_pipe #(
  parameter int DATA_W  = 72,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);

  if (LATENCY == 0) begin : g_comb
    assign rd_data = rd_word;
  end else begin : g_reg
    logic [LATENCY-1:0] ld;
    logic [LATENCY-1:0] vld_q;
    logic [DATA_W-1:0]  dat_d [LATENCY];
    logic [DATA_W-1:0]  dat_q [LATENCY];

    // Load strobe of each stage follows the valid bit one stage back.
    always_comb begin
      ld[0] = rd_fire;
      for (int k = 1; k < LATENCY; k++) ld[k] = vld_q[k-1];
    end

    // Next-state: each stage loads only when fresh data reaches it.
    always_comb begin
      dat_d[0] = ld[0] ? rd_word : dat_q[0];
      for (int k = 1; k < LATENCY; k++) dat_d[k] = ld[k] ? dat_q[k-1] : dat_q[k];
      if (!rst_n) dat_d[LATENCY-1] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= ld;
    end

    always_ff @(posedge clk) begin
      for (int k = 0; k < LATENCY; k++) dat_q[k] <= dat_d[k];
    end

    assign rd_data = dat_q[LATENCY-1];

    // R4: output only moves in the cycle after a valid arrival
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !vld_q[LATENCY-1]) |-> $stable(rd_data));
  end

endmodule

// File: rtl/dpram_bytelane.sv
module dpram_bytelane #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 72,
  parameter int LANE_W  = 8,
  parameter int LATENCY = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     a_en,
  input  logic [DATA_W/LANE_W-1:0] a_we,
  input  logic [ADDR_W-1:0]        a_addr,
  input  logic [DATA_W-1:0]        a_wdata,
  output logic [DATA_W-1:0]        a_rdata,
  input  logic                     b_en,
  input  logic [DATA_W/LANE_W-1:0] b_we,
  input  logic [ADDR_W-1:0]        b_addr,
  input  logic [DATA_W-1:0]        b_wdata,
  output logic [DATA_W-1:0]        b_rdata
);
  import dpram_pkg::*;

  localparam int LANES = DATA_W / LANE_W;
  localparam int NPORT = 2;

  logic                en_v      [NPORT];
  logic [LANES-1:0]    we_v      [NPORT];
  logic [DATA_W-1:0]   word_v    [NPORT];
  logic [DATA_W-1:0]   rdata_v   [NPORT];
  logic                fire_v    [NPORT];

  assign en_v[0] = a_en;
  assign en_v[1] = b_en;
  assign we_v[0] = a_we;
  assign we_v[1] = b_we;

  dpram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_a   (a_en),
    .we_a   (a_we),
    .addr_a (a_addr),
    .din_a  (a_wdata),
    .en_b   (b_en),
    .we_b   (b_we),
    .addr_b (b_addr),
    .din_b  (b_wdata),
    .rd_a   (word_v[0]),
    .rd_b   (word_v[1])
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    port_op_e op;
    assign op        = decode_op(en_v[p], |we_v[p]);
    assign fire_v[p] = (op == OP_READ);

    dpram_read_pipe #(
      .DATA_W  (DATA_W),
      .LATENCY (LATENCY)
    ) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_fire (fire_v[p]),
      .rd_word (word_v[p]),
      .rd_data (rdata_v[p])
    );
  end

  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];

endmodule

// File: tb/test_dpram_bytelane.sv
`timescale 1ns/1ps
module test_dpram_bytelane;

  localparam int TB_LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        a_en, b_en;
  logic [8:0]  a_we, b_we;
  logic [5:0]  a_addr, b_addr;
  logic [71:0] a_din, b_din, a_rdata, b_rdata;

  logic        f_a_en, f_b_en;
  logic [0:0]  f_a_we, f_b_we;
  logic [5:0]  f_a_addr, f_b_addr;
  logic [71:0] f_a_din, f_b_din, f_a_rdata, f_b_rdata;

  dpram_bytelane #(.ADDR_W(6), .DATA_W(72), .LANE_W(8), .LATENCY(TB_LAT)) i_dpram_bytelane (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_din), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_din), .b_rdata(b_rdata));

  dpram_bytelane #(.ADDR_W(6), .DATA_W(72), .LANE_W(72), .LATENCY(0)) i_dpram_bytelane_flat (
    .clk(clk), .rst_n(rst_n),
    .a_en(f_a_en), .a_we(f_a_we), .a_addr(f_a_addr), .a_wdata(f_a_din), .a_rdata(f_a_rdata),
    .b_en(f_b_en), .b_we(f_b_we), .b_addr(f_b_addr), .b_wdata(f_b_din), .b_rdata(f_b_rdata));

  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 0;
  bit          f_on  = 0;
  int unsigned cyc_n = 0;
  logic [71:0] mm [64];
  logic [71:0] fm [64];
  logic        sched_v [2][256];
  logic [71:0] sched_d [2][256];
  logic [71:0] exp_a, exp_b;

  function automatic logic [71:0] rnd72();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[71:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    a_en = 0; a_we = '0; b_en = 0; b_we = '0;
    f_a_en = 0; f_a_we = '0; f_b_en = 0; f_b_we = '0;
  endtask

  task automatic drv_a(input logic en, input logic [8:0] we, input logic [5:0] ad, input logic [71:0] d);
    a_en = en; a_we = we; a_addr = ad; a_din = d;
  endtask

  task automatic drv_b(input logic en, input logic [8:0] we, input logic [5:0] ad, input logic [71:0] d);
    b_en = en; b_we = we; b_addr = ad; b_din = d;
  endtask

  // One clock cycle: model the cycle, advance, check both main outputs.
  task automatic step(input string tag, input string ftag);
    int unsigned slot;
    #1;
    slot = (cyc_n + TB_LAT - 1) % 256;
    if (rst_n) begin
      if (a_en && a_we == '0) begin sched_v[0][slot] = 1; sched_d[0][slot] = mm[a_addr]; end
      if (b_en && b_we == '0) begin sched_v[1][slot] = 1; sched_d[1][slot] = mm[b_addr]; end
    end
    if (f_on) begin
      chk(ftag, "flat port A", f_a_rdata, fm[f_a_addr]);
      chk(ftag, "flat port B", f_b_rdata, fm[f_b_addr]);
    end
    for (int l = 0; l < 9; l++) begin
      if (a_en && a_we[l]) mm[a_addr][l*8 +: 8] = a_din[l*8 +: 8];
      if (b_en && b_we[l]) mm[b_addr][l*8 +: 8] = b_din[l*8 +: 8];
    end
    if (f_a_en && f_a_we[0]) fm[f_a_addr] = f_a_din;
    if (f_b_en && f_b_we[0]) fm[f_b_addr] = f_b_din;
    @(posedge clk);
    slot = cyc_n % 256;
    if (!rst_n) begin
      exp_a = '0; exp_b = '0;
      for (int s = 0; s < 256; s++) begin sched_v[0][s] = 0; sched_v[1][s] = 0; end
    end else begin
      if (sched_v[0][slot]) begin exp_a = sched_d[0][slot]; sched_v[0][slot] = 0; end
      if (sched_v[1][slot]) begin exp_b = sched_d[1][slot]; sched_v[1][slot] = 0; end
    end
    cyc_n++;
    @(negedge clk);
    chk(tag, "port A", a_rdata, exp_a);
    chk(tag, "port B", b_rdata, exp_b);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    for (int s = 0; s < 256; s++) begin sched_v[0][s] = 0; sched_v[1][s] = 0; end
    exp_a = 'x; exp_b = 'x;
    rst_n = 0;
    a_addr = '0; b_addr = '0; a_din = '0; b_din = '0;
    f_a_addr = '0; f_b_addr = '0; f_a_din = '0; f_b_din = '0;
    idle();
    @(negedge clk);
    // R5: reset state of both outputs
    repeat (3) step("R5", "R8");
    rst_n = 1;

    // Fill every word; outputs must stay at zero through writes (R4)
    for (int ad = 0; ad < 64; ad++) begin
      drv_a(1, 9'h1FF, 6'(ad), rnd72());
      f_a_en = 1; f_a_we = 1'b1; f_a_addr = 6'(ad); f_a_din = rnd72();
      step("R4", "R8");
    end
    idle();
    f_on = 1;
    step("R4", "R8");

    // R1: partial lane write then read back
    drv_a(1, 9'h1FF, 6'd5, 72'hFF_EEDD_CCBB_AA99_8877);
    step("R1", "R8");
    drv_a(1, 9'b0_0000_0101, 6'd5, 72'h12_3456_789A_BCDE_F012);
    step("R1", "R8");
    drv_a(1, '0, 6'd5, '0);
    step("R1", "R8");
    idle();
    repeat (TB_LAT) step("R1", "R8");

    // R3: back-to-back reads on both ports
    for (int ad = 1; ad <= 4; ad++) begin
      drv_a(1, '0, 6'(ad), '0);
      drv_b(1, '0, 6'(ad + 40), '0);
      step("R3", "R8");
    end
    idle();
    repeat (TB_LAT + 1) step("R3", "R8");

    // R4: read, then writes and idles must not move the output
    drv_a(1, '0, 6'd7, '0);
    step("R4", "R8");
    drv_a(1, 9'h0F0, 6'd7, rnd72());
    drv_b(1, 9'h001, 6'd8, rnd72());
    step("R4", "R8");
    idle();
    drv_a(0, '0, 6'd3, '0);
    repeat (TB_LAT + 3) step("R4", "R8");

    // R6: A reads the address B writes in the same cycle
    drv_a(1, '0, 6'd9, '0);
    drv_b(1, 9'h1FF, 6'd9, rnd72());
    step("R6", "R8");
    drv_a(1, 9'h1FF, 6'd10, rnd72());
    drv_b(1, '0, 6'd10, '0);
    step("R6", "R8");
    idle();
    repeat (TB_LAT) step("R6", "R8");

    // R7: both ports write disjoint lanes of one word
    drv_a(1, 9'b0_0000_1111, 6'd11, rnd72());
    drv_b(1, 9'b1_1111_0000, 6'd11, rnd72());
    step("R7", "R8");
    drv_a(1, '0, 6'd11, '0);
    drv_b(1, '0, 6'd11, '0);
    step("R7", "R8");
    idle();
    repeat (TB_LAT) step("R7", "R8");

    // R2: port B partial write while A writes elsewhere
    drv_a(1, 9'h1FF, 6'd21, rnd72());
    drv_b(1, 9'b0_1010_1010, 6'd20, rnd72());
    step("R2", "R8");
    drv_a(1, '0, 6'd21, '0);
    drv_b(1, '0, 6'd20, '0);
    step("R2", "R8");
    idle();
    repeat (TB_LAT) step("R2", "R8");

    // R5: mid-run reset drops in-flight reads, keeps contents
    drv_a(1, '0, 6'd5, '0);
    drv_b(1, '0, 6'd11, '0);
    step("R5", "R8");
    idle();
    rst_n = 0;
    step("R5", "R8");
    rst_n = 1;
    step("R5", "R8");
    drv_a(1, '0, 6'd5, '0);
    drv_b(1, '0, 6'd11, '0);
    step("R5", "R8");
    idle();
    repeat (TB_LAT) step("R5", "R8");

    // R9: single-bit enable on the full-word lane instance
    f_a_en = 0; f_a_we = 1'b1; f_a_addr = 6'd30; f_a_din = rnd72();
    f_b_addr = 6'd30;
    step("R9", "R9");
    f_a_en = 1; f_a_we = 1'b0;
    step("R9", "R9");
    f_a_we = 1'b1;
    step("R9", "R9");
    idle();
    step("R9", "R9");

    // Random mix on a few hot words and the full range
    for (int n = 0; n < 500; n++) begin
      logic [5:0] ra, rb;
      ra = ($urandom % 2) ? 6'($urandom % 4) : 6'($urandom);
      rb = ($urandom % 2) ? 6'($urandom % 4) : 6'($urandom);
      drv_a(($urandom % 4) != 0, ($urandom % 2) ? 9'h000 : 9'($urandom), ra, rnd72());
      drv_b(($urandom % 4) != 0, ($urandom % 2) ? 9'h000 : 9'($urandom), rb, rnd72());
      if (a_en && b_en && a_addr == b_addr) b_we = b_we & ~a_we;  // shun overlap
      f_a_en = $urandom % 2; f_a_we = 1'($urandom); f_a_addr = ra; f_a_din = rnd72();
      f_b_en = $urandom % 2; f_b_we = 1'($urandom); f_b_addr = rb; f_b_din = rnd72();
      if (f_a_en && f_b_en && f_a_we[0] && f_a_addr == f_b_addr) f_b_we = 1'b0;
      step("R3", "R8");
    end
    idle();
    repeat (TB_LAT + 1) step("R3", "R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule